// File: doc/BRIEF.md
# Load/Store-Multiple Micro-op Sequencer

This block sits in a decode stage and turns one 32-bit block-transfer instruction (a load or store of several registers at once) into a stream of simple micro-ops. An instruction is taken through a valid/ready port. The block then hands out, one per handshake on a second valid/ready port, these micro-ops in order: an address-setup op, one single-register transfer for each set bit of the register list, and, if base writeback is requested, a synthesized add- or subtract-immediate instruction word that updates the base register.

The instruction layout is fixed: bits [31:28] condition, bits [24:20] the mode field ordered {P,U,S,W,L} (P = pre-index, U = up, S = unsupported flag, W = writeback, L = load), bits [19:16] base register Rn, and bits [15:0] the register list with bit k naming register k. The start offset of the first transfer depends on P and U. Later transfers step by 4 bytes in the direction U selects.

Top module: `lsm_uop_seq`

## Requirements
- R1: An instruction whose mode bit S (bit 22) is 1 is consumed, raises `err_unsup` for exactly the one cycle after acceptance, and emits no micro-op.
- R2: The first micro-op of an accepted instruction has kind 0 (setup), word = {instr[31:16], 16'h0000}, register 0, offset 0 and load 0.
- R3: One transfer micro-op (kind 1, word 0) follows for each set bit of the list, in ascending register index order, each naming exactly one register.
- R4: The first transfer's byte offset is 4N-4 for P=0,U=0; 0 for P=0,U=1; 4N for P=1,U=0; 4 for P=1,U=1, where N is the number of set list bits.
- R5: Each later transfer's offset is the previous one plus 4 when U=1 and minus 4 when U=0.
- R6: Every transfer micro-op's load flag equals the L bit (bit 20). Non-transfer micro-ops report load 0.
- R7: When W=1 a final micro-op carries word = {instr[31:28], 28'h0} | 32'h02400000 | Rn<<16 | Rn<<12 | 4N, with kind 2 (add) if U=1 and kind 3 (subtract) if U=0, register 0 and offset 0.
- R8: Exactly the final micro-op of the sequence has `uop_last` set. With an empty list and W=0 the setup op alone is emitted and is flagged last.
- R9: `in_ready` is low from acceptance until the last-flagged micro-op is handed off, and `in_ready` and `uop_valid` are never high together. Instructions offered while busy are not taken.
- R10: While `uop_valid` is high and `uop_ready` is low, all micro-op fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle and able to take an instruction |
| in_instr | input | 32 | Instruction word |
| err_unsup | output | 1 | One-cycle pulse after an unsupported mode was consumed |
| uop_valid | output | 1 | Micro-op available |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_kind | output | 2 | 0 setup, 1 transfer, 2 writeback add, 3 writeback subtract |
| uop_reg | output | 4 | Register index of a transfer |
| uop_offset | output | 7 | Byte offset of a transfer |
| uop_load | output | 1 | Transfer is a load (1) or a store (0) |
| uop_word | output | 32 | Encoded word for setup and writeback ops |
| uop_last | output | 1 | Final micro-op of the sequence |

## Verification
The bench targets the four P/U offset modes: a mistaken start value shifts every transfer address, and a wrong step direction makes offsets run past the block. It drives a full sixteen-register list, where a narrow counter or offset would wrap the writeback immediate and the start offset, and it drives empty lists with and without writeback, where a design would otherwise emit a phantom transfer or drop the last flag. It stalls the consumer to catch fields that advance without a handshake. It offers instructions while busy and with the S bit set, which a faulty design would take mid-sequence or turn into spurious micro-ops.

// File: rtl/lsm_uop_pkg.sv
package lsm_uop_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned LIST_W   = 16;
    localparam int unsigned IDX_W    = $clog2(LIST_W);
    localparam int unsigned CNT_W    = $clog2(LIST_W + 1);
    localparam int unsigned OFF_W    = CNT_W + 2;
    localparam int unsigned MODE_LSB = 20;
    localparam int unsigned RN_LSB   = 16;
    localparam int unsigned RN_W     = 4;
    localparam int unsigned COND_LSB = 28;
    localparam int unsigned RD_LSB   = 12;
    localparam int unsigned STEP     = 4;
    localparam logic [WORD_W-1:0] WB_OPCODE = 32'h0240_0000;

    typedef enum logic [1:0] {
        UOP_SETUP  = 2'd0,
        UOP_XFER   = 2'd1,
        UOP_WB_ADD = 2'd2,
        UOP_WB_SUB = 2'd3
    } uop_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_XFER  = 2'd2,
        ST_WB    = 2'd3
    } seq_st_e;

    // mode field as it sits in the instruction, MSB first
    typedef struct packed {
        logic pre;
        logic up;
        logic sbit;
        logic wb;
        logic load;
    } mode_t;

    typedef struct packed {
        seq_st_e             st;
        logic [WORD_W-1:0]   instr;
        logic [LIST_W-1:0]   left;
        logic [OFF_W-1:0]    off;
        logic [CNT_W-1:0]    cnt;
        logic                err;
    } seq_t;

endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
    parameter int unsigned W  = 16,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits,
    output logic [CW-1:0] count
);
    // ripple of partial sums, one stage per list bit
    logic [CW-1:0] part [W+1];

    assign part[0] = '0;

    for (genvar g = 0; g < W; g++) begin : g_stage
        assign part[g+1] = part[g] + CW'(bits[g]);
    end

    assign count = part[W];

endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
    parameter int unsigned W  = 16,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic [IW-1:0] idx,
    output logic          single,
    output logic [W-1:0]  rest
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (bits[i]) begin
                idx = IW'(i);
            end
        end
    end

    // clearing the lowest set bit leaves the remaining work
    assign rest   = bits & (bits - W'(1));
    assign single = (bits != '0) && (rest == '0);

endmodule

// File: rtl/lsm_mode_decode.sv
module lsm_mode_decode
    import lsm_uop_pkg::*;
#(
    parameter int unsigned CW = 5,
    parameter int unsigned OW = CW + 2
) (
    input  mode_t          mode,
    input  logic [CW-1:0]  n,
    output logic           legal,
    output logic [OW-1:0]  start_off
);
    logic [OW-1:0] span;

    assign span  = {n, 2'b00};
    assign legal = !mode.sbit;

    always_comb begin
        unique case ({mode.pre, mode.up})
            2'b00:   start_off = span - OW'(STEP);
            2'b01:   start_off = '0;
            2'b10:   start_off = span;
            default: start_off = OW'(STEP);
        endcase
    end

endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
    import lsm_uop_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WORD_W-1:0]   in_instr,
    output logic                err_unsup,
    output logic                uop_valid,
    input  logic                uop_ready,
    output logic [1:0]          uop_kind,
    output logic [IDX_W-1:0]    uop_reg,
    output logic [OFF_W-1:0]    uop_offset,
    output logic                uop_load,
    output logic [WORD_W-1:0]   uop_word,
    output logic                uop_last
);
    seq_t seq_d, seq_q;

    mode_t              in_mode, cur_mode;
    logic [CNT_W-1:0]   in_cnt;
    logic               in_legal;
    logic [OFF_W-1:0]   in_start;
    logic [IDX_W-1:0]   low_idx;
    logic               low_single;
    logic [LIST_W-1:0]  low_rest;
    logic [RN_W-1:0]    cur_rn;
    logic [WORD_W-1:0]  wb_word;

    assign in_mode  = mode_t'(in_instr[MODE_LSB +: 5]);
    assign cur_mode = mode_t'(seq_q.instr[MODE_LSB +: 5]);
    assign cur_rn   = seq_q.instr[RN_LSB +: RN_W];

    lsm_popcount #(.W(LIST_W), .CW(CNT_W)) i_popcount (
        .bits  (in_instr[LIST_W-1:0]),
        .count (in_cnt)
    );

    lsm_mode_decode #(.CW(CNT_W), .OW(OFF_W)) i_mode_decode (
        .mode      (in_mode),
        .n         (in_cnt),
        .legal     (in_legal),
        .start_off (in_start)
    );

    lsm_lowbit #(.W(LIST_W), .IW(IDX_W)) i_lowbit (
        .bits   (seq_q.left),
        .idx    (low_idx),
        .single (low_single),
        .rest   (low_rest)
    );

    // synthesized base-update instruction: cond, opcode, Rn twice, 4N
    always_comb begin
        wb_word = {seq_q.instr[WORD_W-1:COND_LSB], {COND_LSB{1'b0}}};
        wb_word = wb_word | WB_OPCODE;
        wb_word = wb_word | (WORD_W'(cur_rn) << RN_LSB);
        wb_word = wb_word | (WORD_W'(cur_rn) << RD_LSB);
        wb_word = wb_word | WORD_W'({seq_q.cnt, 2'b00});
    end

    // next-state
    always_comb begin
        seq_d     = seq_q;
        seq_d.err = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    if (in_legal) begin
                        seq_d.st    = ST_SETUP;
                        seq_d.instr = in_instr;
                        seq_d.left  = in_instr[LIST_W-1:0];
                        seq_d.cnt   = in_cnt;
                        seq_d.off   = in_start;
                    end else begin
                        seq_d.err = 1'b1;
                    end
                end
            end
            ST_SETUP: begin
                if (uop_ready) begin
                    if (seq_q.left != '0) begin
                        seq_d.st = ST_XFER;
                    end else if (cur_mode.wb) begin
                        seq_d.st = ST_WB;
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end
            end
            ST_XFER: begin
                if (uop_ready) begin
                    seq_d.left = low_rest;
                    seq_d.off  = cur_mode.up ? seq_q.off + OFF_W'(STEP)
                                             : seq_q.off - OFF_W'(STEP);
                    if (low_single) begin
                        seq_d.st = cur_mode.wb ? ST_WB : ST_IDLE;
                    end
                end
            end
            default: begin
                if (uop_ready) begin
                    seq_d.st = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, instr: '0, left: '0, off: '0, cnt: '0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    // output view of the current state
    always_comb begin
        uop_kind   = UOP_SETUP;
        uop_reg    = '0;
        uop_offset = '0;
        uop_load   = 1'b0;
        uop_word   = '0;
        uop_last   = 1'b0;
        unique case (seq_q.st)
            ST_SETUP: begin
                uop_word = {seq_q.instr[WORD_W-1:RN_LSB], {RN_LSB{1'b0}}};
                uop_last = (seq_q.left == '0) && !cur_mode.wb;
            end
            ST_XFER: begin
                uop_kind   = UOP_XFER;
                uop_reg    = low_idx;
                uop_offset = seq_q.off;
                uop_load   = cur_mode.load;
                uop_last   = low_single && !cur_mode.wb;
            end
            ST_WB: begin
                uop_kind = cur_mode.up ? UOP_WB_ADD : UOP_WB_SUB;
                uop_word = wb_word;
                uop_last = 1'b1;
            end
            default: ;
        endcase
    end

    assign uop_valid = (seq_q.st != ST_IDLE);
    assign in_ready  = (seq_q.st == ST_IDLE);
    assign err_unsup = seq_q.err;

endmodule

// File: rtl/lsm_uop_seq_chk.sv
module lsm_uop_seq_chk
    import lsm_uop_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic [WORD_W-1:0]   in_instr,
    input logic                err_unsup,
    input logic                uop_valid,
    input logic                uop_ready,
    input logic [1:0]          uop_kind,
    input logic [IDX_W-1:0]    uop_reg,
    input logic [OFF_W-1:0]    uop_offset,
    input logic                uop_load,
    input logic [WORD_W-1:0]   uop_word,
    input logic                uop_last
);
    // R1
    unsup_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_instr[MODE_LSB+2]) |=> (err_unsup && !uop_valid));

    // R2
    setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_instr[MODE_LSB+2])
            |=> (uop_valid && uop_kind == UOP_SETUP));

    // R5
    offset_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_kind == UOP_XFER) |-> (uop_offset[1:0] == 2'b00));

    // R7
    wb_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_kind[1]) |-> uop_last);

    // R8
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && uop_last) |=> (!uop_valid && in_ready));

    // R9
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && uop_valid));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_kind) && $stable(uop_reg)
            && $stable(uop_offset) && $stable(uop_load) && $stable(uop_word)
            && $stable(uop_last)));

endmodule

bind lsm_uop_seq lsm_uop_seq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_instr   (in_instr),
    .err_unsup  (err_unsup),
    .uop_valid  (uop_valid),
    .uop_ready  (uop_ready),
    .uop_kind   (uop_kind),
    .uop_reg    (uop_reg),
    .uop_offset (uop_offset),
    .uop_load   (uop_load),
    .uop_word   (uop_word),
    .uop_last   (uop_last)
);

// File: tb/test_lsm_uop_seq.sv
module test_lsm_uop_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_instr = '0;
    logic        err_unsup;
    logic        uop_valid;
    logic        uop_ready = 1'b0;
    logic [1:0]  uop_kind;
    logic [3:0]  uop_reg;
    logic [6:0]  uop_offset;
    logic        uop_load;
    logic [31:0] uop_word;
    logic        uop_last;

    int checks = 0;
    int errors = 0;

    // expected sequence
    logic [1:0]  e_kind [20];
    logic [3:0]  e_reg  [20];
    logic [6:0]  e_off  [20];
    logic        e_load [20];
    logic [31:0] e_word [20];
    logic        e_last [20];
    int          e_cnt;

    always #5 clk = ~clk;

    lsm_uop_seq i_lsm_uop_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .err_unsup(err_unsup), .uop_valid(uop_valid),
        .uop_ready(uop_ready), .uop_kind(uop_kind), .uop_reg(uop_reg),
        .uop_offset(uop_offset), .uop_load(uop_load), .uop_word(uop_word),
        .uop_last(uop_last)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic p, u, s, w, l,
                                       input logic [3:0] rn, input logic [15:0] list);
        return {4'hE, 3'b100, p, u, s, w, l, rn, list};
    endfunction

    // reference built from the requirement text
    task automatic build(input logic [31:0] ins);
        int n = 0;
        int off;
        int k = 0;
        logic p = ins[24], u = ins[23], w = ins[21], l = ins[20];
        for (int j = 0; j < 16; j++) if (ins[j]) n++;
        if (!p && !u) off = 4 * n - 4;
        else if (!p && u) off = 0;
        else if (p && !u) off = 4 * n;
        else off = 4;
        e_kind[0] = 2'd0; e_reg[0] = 0; e_off[0] = 0; e_load[0] = 0;
        e_word[0] = {ins[31:16], 16'h0000}; e_last[0] = 0;
        k = 1;
        for (int j = 0; j < 16; j++) begin
            if (ins[j]) begin
                e_kind[k] = 2'd1; e_reg[k] = 4'(j); e_off[k] = 7'(off);
                e_load[k] = l; e_word[k] = 0; e_last[k] = 0;
                off = u ? off + 4 : off - 4;
                k++;
            end
        end
        if (w) begin
            e_kind[k] = u ? 2'd2 : 2'd3; e_reg[k] = 0; e_off[k] = 0; e_load[k] = 0;
            e_word[k] = {ins[31:28], 28'h0} | 32'h0240_0000 | (32'(ins[19:16]) << 16)
                        | (32'(ins[19:16]) << 12) | 32'(4 * n);
            e_last[k] = 0;
            k++;
        end
        e_last[k-1] = 1;
        e_cnt = k;
    endtask

    task automatic check_op(input int i, input string sfx);
        chk({"R9 valid ", sfx}, 32'(uop_valid), 32'd1);
        chk({"R9 busy ", sfx}, 32'(in_ready), 32'd0);
        chk({"R2/R3/R7 kind ", sfx}, 32'(uop_kind), 32'(e_kind[i]));
        chk({"R3 reg ", sfx}, 32'(uop_reg), 32'(e_reg[i]));
        chk({"R4/R5 offset ", sfx}, 32'(uop_offset), 32'(e_off[i]));
        chk({"R6 load ", sfx}, 32'(uop_load), 32'(e_load[i]));
        chk({"R2/R7 word ", sfx}, uop_word, e_word[i]);
        chk({"R8 last ", sfx}, 32'(uop_last), 32'(e_last[i]));
    endtask

    // send one instruction and drain its micro-ops; stall bit i holds op i
    task automatic run(input string name, input logic [31:0] ins,
                       input logic [7:0] stall, input bit noise);
        build(ins);
        @(negedge clk);
        in_valid = 1'b1; in_instr = ins;
        chk({"R9 ready ", name}, 32'(in_ready), 32'd1);
        @(negedge clk);
        if (noise) in_instr = 32'hE8BF_FFFF;
        else in_valid = 1'b0;
        for (int i = 0; i < e_cnt; i++) begin
            check_op(i, name);
            if (stall[i % 8]) begin
                repeat (2) @(negedge clk);
                check_op(i, {"R10 ", name});
            end
            if (i == e_cnt - 1) in_valid = 1'b0;
            uop_ready = 1'b1;
            @(negedge clk);
            uop_ready = 1'b0;
        end
        chk({"R8 done ", name}, 32'(uop_valid), 32'd0);
        chk({"R9 idle ", name}, 32'(in_ready), 32'd1);
        chk({"R1 no err ", name}, 32'(err_unsup), 32'd0);
    endtask

    task automatic t_unsup();
        @(negedge clk);
        in_valid = 1'b1; in_instr = mk(1, 1, 1, 1, 1, 4'h2, 16'h00FF);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 err pulse", 32'(err_unsup), 32'd1);
        chk("R1 no uop", 32'(uop_valid), 32'd0);
        chk("R1 ready", 32'(in_ready), 32'd1);
        @(negedge clk);
        chk("R1 err ends", 32'(err_unsup), 32'd0);
        chk("R1 still none", 32'(uop_valid), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset ready", 32'(in_ready), 32'd1);
        chk("R9 reset valid", 32'(uop_valid), 32'd0);
        chk("R1 reset err", 32'(err_unsup), 32'd0);
        // increment-after, writeback, load
        run("ia_wb_ld", mk(0, 1, 0, 1, 1, 4'h3, 16'h8421), 8'h00, 0);
        // decrement-after, store, no writeback
        run("da_st", mk(0, 0, 0, 0, 0, 4'h5, 16'h00F0), 8'h05, 0);
        // decrement-before, full list, writeback, stalls
        run("db_full", mk(1, 0, 0, 1, 0, 4'hD, 16'hFFFF), 8'hA3, 0);
        // increment-before, single register
        run("ib_one", mk(1, 1, 0, 0, 1, 4'h1, 16'h0001), 8'h02, 0);
        // increment-before, full list, writeback add
        run("ib_full", mk(1, 1, 0, 1, 1, 4'h7, 16'hFFFF), 8'h00, 0);
        // empty list, setup alone is last
        run("empty", mk(0, 1, 0, 0, 1, 4'h4, 16'h0000), 8'h01, 0);
        // empty list with writeback: immediate 0
        run("empty_wb", mk(1, 0, 0, 1, 0, 4'h9, 16'h0000), 8'h00, 0);
        // unsupported mode
        t_unsup();
        // offers while busy are ignored
        run("busy_noise", mk(0, 0, 0, 1, 1, 4'hA, 16'h1248), 8'h10, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule